// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block is an SPI bus master that moves one frame at a time. A one-word transmit holding register accepts data through a valid/ready handshake. A one-word receive register presents each captured word until the consumer acknowledges it. The engine drives the serial clock, the serial output and one of four select lines, and it samples the serial input.

The serial clock half-period is `cfg_div + 1` system clocks. Every frame is framed by three delays, each programmable from 1 to 8 serial clock periods:
- a setup delay after select asserts,
- a hold delay after the last clock edge,
- an idle gap before the next frame may begin.

The following settings are taken from the configuration inputs:
- clock polarity and phase
- bit order
- frame width
- parity
- byte swap
- transmit-only operation
- idle level of the serial output
- select polarity and select index

The configuration must stay constant while `busy` is high. Rather than overwrite an unread received word, the engine freezes the serial clock just before the final edge of the next frame. It resumes once that word has been read.

Top module: `spi_frame_master`

## Requirements
- R1: `sck` rests at `cfg_cpol` whenever no frame is shifting. With `cfg_cpha`=0 the input is sampled on the 1st, 3rd, ... edges and the output changes on the 2nd, 4th, ... edges. With `cfg_cpha`=1 these roles swap. Each frame has exactly 2*width edges.
- R2: The time from select assertion to the first `sck` edge is 2*(`cfg_lead`+1)*(`cfg_div`+1) system clocks.
- R3: The time from the last `sck` edge to select negation is 2*(`cfg_lag`+1)*(`cfg_div`+1) system clocks.
- R4: Between the negation of one frame's select and the assertion for a queued next frame there are 2*(`cfg_gap`+1)*(`cfg_div`+1) system clocks.
- R5: With `cfg_par_en`=1, bit 0 of the frame (after any swap) is replaced by a parity bit. With `cfg_par_odd`=1 this makes the number of ones in the frame odd; otherwise it makes the number even.
- R6: The frame width is `cfg_width` (4..32). With `cfg_lsb_first`=1 bit 0 is shifted first; otherwise bit width-1 is shifted first. Received bits are placed by the same rule.
- R7: `cfg_ss_pol`=0 selects an active-low select level and 1 selects active-high. Only line `ss[cfg_ss_sel]` is ever active, and only from the start of the setup delay to the end of the hold delay.
- R8: While select is inactive, `cfg_idle` decides `mosi`. The values 00 and 01 hold the last driven bit, 10 forces 0 and 11 forces 1.
- R9: If `rx_valid` is still high when a frame reaches its final `sck` edge, `sck` holds its level and `rx_data` keeps its value. The frame completes only after `rx_read` is asserted.
- R10: With `cfg_tx_only`=1, `miso` is ignored and `rx_valid` never rises. With 0, every frame stores one word and sets `rx_valid`.
- R11: With `cfg_swap`=1 and a width of 16 or 32, the byte order is reversed between the buffer word and the shifted word, in both directions. Other widths are unaffected.
- R12: `busy` is high from select assertion until the end of the idle gap. `done` pulses for one cycle when a gap ends with no frame queued. `tx_ready` is low while a word waits in the transmit register.
- R13: After reset: `busy`, `done` and `rx_valid` are 0, `tx_ready` is 1, all select lines are inactive and `sck` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on odd edges, 1: sample on even edges |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_width | input | 6 | Frame width in bits, 4..32 |
| cfg_par_en | input | 1 | Parity insertion enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_swap | input | 1 | Byte swap for 16/32-bit frames |
| cfg_tx_only | input | 1 | Transmit-only operation |
| cfg_idle | input | 2 | Serial output idle behaviour |
| cfg_ss_pol | input | 1 | Select active level |
| cfg_ss_sel | input | 2 | Index of the select line to drive |
| cfg_div | input | 8 | Half-period divider, half-period = cfg_div+1 clocks |
| cfg_lead | input | 3 | Setup delay minus one, in serial clock periods |
| cfg_lag | input | 3 | Hold delay minus one, in serial clock periods |
| cfg_gap | input | 3 | Idle gap minus one, in serial clock periods |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word |
| tx_ready | output | 1 | Transmit register empty |
| rx_valid | output | 1 | Received word waiting |
| rx_data | output | 32 | Received word |
| rx_read | input | 1 | Acknowledge of the received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 4 | Select lines |
| busy | output | 1 | Frame activity in progress |
| done | output | 1 | One-cycle end-of-queue pulse |

## Verification
The bench uses the default parameters: a 32-bit maximum frame and an 8-bit divider. These defaults allow both byte-swap widths, 16 and 32, to be reached. At runtime the divider is kept between 0 and 3. The smallest value gives single-clock half-periods, where every timing formula is at its tightest, and the larger ones confirm that the delays scale with the divider. All three delays cover their full 1..8 range through random draws. Back-to-back queued frames make the idle gap and the receive stall observable at the pins.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int MAXW = 32,
  parameter int DIVW = 8,
  localparam int WW = $clog2(MAXW + 1),
  localparam int KW = WW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic [WW-1:0]   cfg_width,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_swap,
  input  logic            cfg_tx_only,
  input  logic [1:0]      cfg_idle,
  input  logic            cfg_ss_pol,
  input  logic [1:0]      cfg_ss_sel,
  input  logic [DIVW-1:0] cfg_div,
  input  logic [2:0]      cfg_lead,
  input  logic [2:0]      cfg_lag,
  input  logic [2:0]      cfg_gap,
  input  logic            tx_valid,
  input  logic [MAXW-1:0] tx_data,
  output logic            tx_ready,
  output logic            rx_valid,
  output logic [MAXW-1:0] rx_data,
  input  logic            rx_read,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [3:0]      ss,
  output logic            busy,
  output logic            done
);

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_LAG, ST_GAP} st_t;

  function automatic logic [MAXW-1:0] f_mask(input logic [MAXW-1:0] v, input int w);
    f_mask = '0;
    for (int i = 0; i < MAXW; i++) if (i < w) f_mask[i] = v[i];
  endfunction

  function automatic logic [MAXW-1:0] f_rev(input logic [MAXW-1:0] v, input int w);
    f_rev = '0;
    for (int i = 0; i < MAXW; i++) if (i < w) f_rev[i] = v[w-1-i];
  endfunction

  function automatic logic [MAXW-1:0] f_swap(input logic [MAXW-1:0] v, input int w, input logic en);
    f_swap = v;
    for (int i = 0; i < MAXW; i++) begin
      if (en && w == 16 && i < 16) f_swap[i] = v[i ^ 8];
      if (en && w == 32 && i < 32) f_swap[i] = v[i ^ 24];
    end
  endfunction

  st_t             state;
  logic [DIVW-1:0] cnt;
  logic [3:0]      hc;
  logic [KW-1:0]   k;
  logic [MAXW-1:0] txb, txs, acc;
  logic            txb_full, mosi_r, ph, rx_valid_r, done_r;
  logic [MAXW-1:0] rx_data_r;

  int              w;
  logic            tick, stall, adv, smp, ss_act;
  logic [KW-1:0]   last_k;
  logic [WW-1:0]   bidx, bnext;
  logic [MAXW-1:0] fr_sw, fr_par, fr_wire, acc_n, rx_word;

  assign w      = int'(cfg_width);
  assign last_k = {cfg_width, 1'b0} - 1'b1;
  assign bidx   = k[KW-1:1];
  assign bnext  = bidx + 1'b1;
  assign tick   = (cnt == cfg_div);
  assign stall  = (state == ST_SHIFT) && (k == last_k) && rx_valid_r && !cfg_tx_only;
  assign adv    = tick && !stall;
  assign smp    = (k[0] == cfg_cpha);
  assign ss_act = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_LAG);

  always_comb begin
    fr_sw  = f_swap(f_mask(txb, w), w, cfg_swap);
    fr_par = fr_sw;
    if (cfg_par_en) fr_par[0] = (^fr_sw[MAXW-1:1]) ^ cfg_par_odd;
    fr_wire = cfg_lsb_first ? fr_par : f_rev(fr_par, w);
    acc_n = acc;
    if (state == ST_SHIFT && smp) acc_n[bidx] = miso;
    rx_word = f_swap(cfg_lsb_first ? f_mask(acc_n, w) : f_rev(acc_n, w), w, cfg_swap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; hc <= '0; k <= '0;
      txb <= '0; txs <= '0; acc <= '0; txb_full <= 1'b0;
      mosi_r <= 1'b0; ph <= 1'b0; rx_valid_r <= 1'b0; rx_data_r <= '0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (rx_read) rx_valid_r <= 1'b0;
      if (tx_valid && !txb_full) begin
        txb <= tx_data;
        txb_full <= 1'b1;
      end
      if (state == ST_IDLE) cnt <= '0;
      else if (tick) cnt <= stall ? cnt : '0;
      else cnt <= cnt + 1'b1;

      case (state)
        ST_IDLE: if (txb_full) begin
          state <= ST_LEAD; hc <= '0; acc <= '0; ph <= 1'b0;
          txs <= fr_wire; txb_full <= 1'b0;
          if (!cfg_cpha) mosi_r <= fr_wire[0];
        end
        ST_LEAD: if (adv) begin
          if (hc == {cfg_lead, 1'b0}) begin state <= ST_SHIFT; k <= '0; end
          else hc <= hc + 1'b1;
        end
        ST_SHIFT: if (adv) begin
          ph  <= ~ph;
          acc <= acc_n;
          if (cfg_cpha) begin
            if (!k[0]) mosi_r <= txs[bidx];
          end else if (k[0] && k != last_k) mosi_r <= txs[bnext];
          if (k == last_k) begin
            state <= ST_LAG; hc <= '0;
            if (!cfg_tx_only) begin rx_data_r <= rx_word; rx_valid_r <= 1'b1; end
          end else k <= k + 1'b1;
        end
        ST_LAG: if (adv) begin
          if (hc == {cfg_lag, 1'b1}) begin state <= ST_GAP; hc <= '0; end
          else hc <= hc + 1'b1;
        end
        ST_GAP: if (adv) begin
          hc <= '0;
          if (hc == {cfg_gap, 1'b1}) begin
            if (txb_full) begin
              state <= ST_LEAD; acc <= '0; ph <= 1'b0;
              txs <= fr_wire; txb_full <= 1'b0;
              if (!cfg_cpha) mosi_r <= fr_wire[0];
            end else begin
              state <= ST_IDLE; done_r <= 1'b1;
            end
          end else hc <= hc + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_ss
    assign ss[g] = (ss_act && cfg_ss_sel == 2'(g)) ? cfg_ss_pol : ~cfg_ss_pol;
  end

  assign sck      = ph ^ cfg_cpol;
  assign mosi     = (ss_act || !cfg_idle[1]) ? mosi_r : cfg_idle[0];
  assign tx_ready = !txb_full;
  assign rx_valid = rx_valid_r;
  assign rx_data  = rx_data_r;
  assign busy     = (state != ST_IDLE);
  assign done     = done_r;

  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $countones(ss ^ {4{~cfg_ss_pol}}) <= 1); // R7
  AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n) (state != ST_SHIFT) |-> (sck == cfg_cpol)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(sck)); // R9
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid_r && !rx_read) |=> (rx_valid_r && $stable(rx_data_r))); // R9
  AST_TXONLY_NORX: assert property (@(posedge clk) disable iff (!rst_n) (cfg_tx_only && !rx_valid_r && !busy) |=> !rx_valid_r); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !ss_act)); // R12

endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0, paren = 0, parodd = 0, swp = 0, txo = 0, sspol = 0;
  logic [1:0] idle = 0, sel = 0;
  logic [5:0] w = 8;
  logic [7:0] div = 0;
  logic [2:0] lead = 0, lag = 0, gap = 0;
  logic tx_valid = 0, rx_read = 0, miso = 0;
  logic [31:0] tx_data = 0;
  logic tx_ready, rx_valid, sck, mosi, busy, done;
  logic [31:0] rx_data;
  logic [3:0] ss;

  spi_frame_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb),
    .cfg_width(w), .cfg_par_en(paren), .cfg_par_odd(parodd), .cfg_swap(swp),
    .cfg_tx_only(txo), .cfg_idle(idle), .cfg_ss_pol(sspol), .cfg_ss_sel(sel),
    .cfg_div(div), .cfg_lead(lead), .cfg_lag(lag), .cfg_gap(gap),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_read(rx_read),
    .sck(sck), .mosi(mosi), .miso(miso), .ss(ss), .busy(busy), .done(done));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, finished = 0;
  int t_on = 0, t_off = 0, t_first = 0, t_last = 0, gap_meas = 0, edges = 0;
  int done_cnt = 0, idle_bad = 0, ss_bad = 0;
  logic [31:0] mbits = 0, sbits = 0;
  logic pss = 0, psck = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic on;
    on = (ss[sel] == sspol);
    for (int j = 0; j < 4; j++) if (j != int'(sel) && ss[j] != ~sspol) ss_bad++;
    if (!on) begin
      if (sck != cpol) idle_bad++;
      if (idle[1] && mosi != idle[0]) idle_bad++;
    end
    if (on && !pss) begin
      t_on = cyc; gap_meas = cyc - t_off; edges = 0; mbits = 0;
      if (!cpha) miso = sbits[0];
    end
    if (on && sck != psck) begin
      edges++;
      if (edges == 1) t_first = cyc;
      t_last = cyc;
      if ((edges % 2 == 1) != cpha) mbits[(edges-1)/2] = mosi;
      else if (!cpha) begin if (edges/2 < int'(w)) miso = sbits[edges/2]; end
      else miso = sbits[(edges-1)/2];
    end
    if (!on && pss) t_off = cyc;
    if (done) done_cnt++;
    pss = on; psck = sck;
  end

  function automatic logic [31:0] msk(input logic [31:0] v, input int n);
    return (n >= 32) ? v : (v & ((32'd1 << n) - 1));
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] v, input int n, input bit en);
    if (en && n == 16) return {16'd0, v[7:0], v[15:8]};
    if (en && n == 32) return {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

  function automatic logic [31:0] flip(input logic [31:0] v, input int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  function automatic logic [31:0] e_wire(input logic [31:0] d);
    logic [31:0] m;
    m = bswap(msk(d, int'(w)), int'(w), swp);
    if (paren) begin m[0] = 1'b0; m[0] = (^m) ^ parodd; end
    return lsb ? m : flip(m, int'(w));
  endfunction

  function automatic logic [31:0] e_rx(input logic [31:0] s);
    return bswap(lsb ? msk(s, int'(w)) : flip(s, int'(w)), int'(w), swp);
  endfunction

  task automatic send(input logic [31:0] d);
    @(posedge clk); #1;
    while (!tx_ready) begin @(posedge clk); #1; end
    tx_data = d; tx_valid = 1;
    @(posedge clk); #1;
    tx_valid = 0;
  endtask

  task automatic pop();
    @(posedge clk); #1 rx_read = 1;
    @(posedge clk); #1 rx_read = 0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic frame_checks(input logic [31:0] d, input int d0);
    int per;
    logic [31:0] ew;
    per = int'(div) + 1;
    ew = e_wire(d);
    chk(edges == 2*int'(w), "R1 edge count", edges, 2*int'(w));
    chk(msk(mbits, int'(w)) == ew, "R6 R5 R11 shifted bits", mbits, ew);
    chk(t_first - t_on == 2*(int'(lead)+1)*per, "R2 setup delay", t_first - t_on, 2*(int'(lead)+1)*per);
    chk(t_off - t_last == 2*(int'(lag)+1)*per, "R3 hold delay", t_off - t_last, 2*(int'(lag)+1)*per);
    chk(done_cnt - d0 == 1 && !busy, "R12 single done pulse", done_cnt - d0, 1);
    chk(idle_bad == 0, "R1 R8 idle levels", idle_bad, 0);
    chk(ss_bad == 0, "R7 unselected lines quiet", ss_bad, 0);
    if (!idle[1]) chk(mosi == ew[int'(w)-1], "R8 hold last bit", mosi, ew[int'(w)-1]);
    if (txo) chk(!rx_valid, "R10 no receive in tx-only", rx_valid, 0);
    else begin
      chk(rx_valid && rx_data == e_rx(sbits), "R6 R11 received word", rx_data, e_rx(sbits));
      pop();
    end
  endtask

  task automatic run_frame(input logic [31:0] d);
    int d0;
    d0 = done_cnt; idle_bad = 0; ss_bad = 0;
    sbits = $urandom;
    send(d);
    wait_done(d0);
    frame_checks(d, d0);
  endtask

  task automatic setcfg();
    @(posedge clk); #1;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !rx_valid && tx_ready, "R13 reset flags", {busy, done, rx_valid, tx_ready}, 4'b0001);
    chk(ss == 4'hF && sck == 1'b0, "R13 reset pins", {ss, sck}, 5'b11110);

    setcfg(); w = 8; div = 1; lead = 2; lag = 1; gap = 0;
    run_frame(32'hA5);
    setcfg(); cpol = 1; cpha = 1; lsb = 1; sspol = 1; sel = 2; idle = 2'b11; div = 0;
    run_frame(32'h3C);
    setcfg(); cpol = 0; cpha = 0; lsb = 0; sspol = 0; sel = 1; idle = 2'b10; paren = 1; parodd = 1;
    run_frame(32'h00);
    chk(($countones(msk(mbits, 8)) % 2) == 1, "R5 odd parity count", mbits, 1);
    setcfg(); parodd = 0;
    run_frame(32'hFE);
    chk(($countones(msk(mbits, 8)) % 2) == 0, "R5 even parity count", mbits, 0);
    setcfg(); paren = 0; swp = 1; w = 16;
    run_frame(32'h1234);
    setcfg(); w = 32; lsb = 1;
    run_frame(32'hDEADBEEF);
    setcfg(); w = 12;
    run_frame(32'hABC);
    setcfg(); w = 4; swp = 0; idle = 2'b00; cpha = 1; lead = 7; lag = 7;
    run_frame(32'h9);

    begin : gap_test
      int d0;
      setcfg(); txo = 1; w = 8; gap = 3; div = 2; lead = 0; lag = 0; cpha = 0;
      d0 = done_cnt; idle_bad = 0; ss_bad = 0; sbits = 0;
      send(32'h81);
      send(32'h7E);
      while (edges < 2) @(negedge clk);
      chk(busy && !tx_ready, "R12 busy and queue held", {busy, tx_ready}, 2'b10);
      wait_done(d0);
      chk(gap_meas == 2*4*3, "R4 next-access gap", gap_meas, 24);
      chk(msk(mbits, 8) == e_wire(32'h7E), "R6 second queued frame", mbits, e_wire(32'h7E));
      chk(done_cnt - d0 == 1, "R12 done once for queue", done_cnt - d0, 1);
      chk(!rx_valid, "R10 tx-only stores nothing", rx_valid, 0);
    end

    begin : stall_test
      int d0, hold;
      logic [31:0] first;
      setcfg(); txo = 0; gap = 0; div = 1;
      sbits = $urandom;
      d0 = done_cnt;
      send(32'h55);
      wait_done(d0);
      first = e_rx(sbits);
      chk(rx_valid && rx_data == first, "R9 first word held", rx_data, first);
      sbits = $urandom;
      d0 = done_cnt;
      send(32'hC3);
      hold = 0;
      while (edges < 15 && hold < 5000) begin @(negedge clk); hold++; end
      repeat (40) @(negedge clk);
      chk(edges == 15 && busy, "R9 clock frozen at final edge", edges, 15);
      chk(rx_data == first, "R9 unread word kept", rx_data, first);
      pop();
      wait_done(d0);
      chk(edges == 16, "R9 frame completes after read", edges, 16);
      chk(rx_valid && rx_data == e_rx(sbits), "R9 second word stored", rx_data, e_rx(sbits));
      pop();
    end

    for (int n = 0; n < 50; n++) begin
      setcfg();
      cpol = 1'($urandom); cpha = 1'($urandom); lsb = 1'($urandom);
      paren = 1'($urandom); parodd = 1'($urandom); swp = 1'($urandom);
      txo = ($urandom % 4) == 0; sspol = 1'($urandom); sel = 2'($urandom);
      idle = 2'($urandom); div = 8'($urandom % 4);
      lead = 3'($urandom); lag = 3'($urandom); gap = 3'($urandom);
      case ($urandom % 4)
        0: w = 16;
        1: w = 32;
        default: w = 6'(4 + $urandom % 29);
      endcase
      run_frame($urandom);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R12 actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule